// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of peripheral sources and gives each source a programmable 4-bit priority level. On every clock it picks the highest-level pending request. When two requests share a level, the lower source index wins. The winning level is compared against the CPU's 4-bit mask. A request to the CPU is raised only when the level is strictly greater than the mask.

When the CPU acknowledges with a one-cycle pulse, the block captures an event code that is unique to the winning source. It also sets a block bit that holds off further CPU requests until a return-from-interrupt pulse clears it. The mask input is never changed by the block. Requests are never discarded. A source stays pending for as long as it drives its line.

The block also supplies a single handler entry address, shared by all sources, equal to the vector base plus 0x600. Software identifies the source from the event code. Priority levels are written one source at a time through a small write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `cpu_irq`, `blk` and `evt_code` are 0 and every source level is 0, so no request raises `cpu_irq` even with the mask at 0.
- R2: The accepted source is the asserted request with the numerically highest level. Its event code is EVT_BASE + index*EVT_STEP, which is 0x400 + index*0x20 with the default parameters.
- R3: Among asserted requests that share the highest level, the lowest source index is accepted.
- R4: `cpu_irq` is 1 only when the winning level is strictly greater than `cpu_mask`. A winning level equal to the mask does not raise it.
- R5: `cpu_irq` is a registered output. A change on the request or mask inputs shows on it at the next rising clock edge and not before.
- R6: A `cpu_ack` pulse while `cpu_irq` is 1 loads the event code of the registered winner and sets `blk` to 1 at that edge. At the same edge `cpu_irq` drops to 0.
- R7: While `blk` is 1, `cpu_irq` stays 0 whatever the requests and the mask are.
- R8: A `cpu_rte` pulse clears `blk` at the next edge. If an acknowledge is accepted in the same cycle, the acknowledge wins. `cpu_irq` re-evaluates at that same edge, so a still-pending request above the mask raises it at once.
- R9: A `cpu_ack` while `cpu_irq` is 0 is ignored: `evt_code` and `blk` keep their values.
- R10: `handler_addr` equals `vec_base` + 0x600, computed modulo 2^32 without a clock.
- R11: A request that loses arbitration stays pending. It is accepted after the higher request is removed and `blk` is cleared.
- R12: A write with `cfg_we` = 1 stores `cfg_lvl` as the level of source `cfg_idx`, and the new level is used from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | N_SRC | Level-sensitive request, one bit per source |
| cfg_we | input | 1 | Level write enable |
| cfg_idx | input | IDX_W | Source index of the level write |
| cfg_lvl | input | LVL_W | Level value to write |
| cpu_mask | input | LVL_W | CPU interrupt mask level |
| cpu_ack | input | 1 | One-cycle acknowledge from the CPU |
| cpu_rte | input | 1 | One-cycle return-from-interrupt pulse |
| vec_base | input | ADDR_W | Vector base address |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| blk | output | 1 | Block bit, set on acceptance |
| evt_code | output | EVT_W | Event code of the last accepted source |
| handler_addr | output | ADDR_W | Shared handler entry address |

## Verification
A corrupted level register or a wrong arbitration result shows up as a wrong `cpu_irq` decision one edge after the request pattern is applied. It also shows up as a wrong `evt_code` on the edge after the acknowledge. A stuck or mis-timed block bit appears as `cpu_irq` rising while `blk` is 1, or as `cpu_irq` failing to return on the edge after `cpu_rte`. The bench sweeps every request pattern against every mask for three level layouts: distinct levels, all levels equal, and pairwise ties. This exposes any such fault within a few cycles of the pattern that provokes it.

// File: rtl/irqc_pkg.sv
// Package: shared constants of the prioritized interrupt controller.
// Assumes: handler offset is fixed and common to every source.
package irqc_pkg;
    localparam logic [31:0] HANDLER_OFS = 32'h0000_0600;
endpackage

// File: rtl/irqc_level_regs.sv
// Module: irqc_level_regs
// Holds one programmable priority level per source; writes one source
// per cycle. Assumes cfg_idx < N whenever cfg_we is high.
module irqc_level_regs #(
    parameter int N  = 8,
    parameter int LW = 4,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   idx,
    input  logic [LW-1:0]   lvl,
    output logic [N*LW-1:0] levels
);
    for (genvar i = 0; i < N; i++) begin : g_lvl
        // Level storage of source i, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                levels[i*LW +: LW] <= '0;
            else if (we && (idx == IW'(i)))
                levels[i*LW +: LW] <= lvl;
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Module: irqc_arbiter
// Combinational selection of the highest-level asserted request;
// ties go to the lower index. Assumes nothing about request timing.
module irqc_arbiter #(
    parameter int N  = 8,
    parameter int LW = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [N*LW-1:0] levels,
    output logic            valid,
    output logic [IW-1:0]   win_idx,
    output logic [LW-1:0]   win_lvl
);
    // Scan sources upward; only a strictly higher level replaces the winner.
    always_comb begin
        valid   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!valid || (levels[i*LW +: LW] > win_lvl))) begin
                valid   = 1'b1;
                win_idx = IW'(i);
                win_lvl = levels[i*LW +: LW];
            end
        end
    end

    // Winner must be an asserted request (R2).
    always_comb begin
        p_win_is_req_r2: assert (!valid || req[win_idx]);
    end
endmodule

// File: rtl/irqc_gate.sv
// Module: irqc_gate
// Mask compare, CPU request register, block bit and event code capture.
// Assumes cpu_ack and cpu_rte are single-cycle pulses from the CPU side.
module irqc_gate #(
    parameter int            LW       = 4,
    parameter int            IW       = 3,
    parameter int            EW       = 12,
    parameter logic [EW-1:0] EVT_BASE = 12'h400,
    parameter logic [EW-1:0] EVT_STEP = 12'h020
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [IW-1:0] win_idx,
    input  logic [LW-1:0] win_lvl,
    input  logic [LW-1:0] mask,
    input  logic          ack,
    input  logic          rte,
    output logic          irq_q,
    output logic          blk_q,
    output logic [EW-1:0] evt_code
);
    logic          accept;
    logic          blk_d;
    logic          hit;
    logic [IW-1:0] idx_q;

    // Acknowledge counts only against a raised request.
    assign accept = ack && irq_q;
    // Next block state: acceptance sets, return clears, acceptance wins.
    assign blk_d  = accept ? 1'b1 : (rte ? 1'b0 : blk_q);
    // Strictly-above-mask test of the current winner.
    assign hit    = valid && (win_lvl > mask);

    // Request, winner and block registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            blk_q <= 1'b0;
            idx_q <= '0;
        end else begin
            irq_q <= hit && !blk_d;
            blk_q <= blk_d;
            idx_q <= win_idx;
        end
    end

    // Event code capture of the registered winner on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_code <= '0;
        else if (accept)
            evt_code <= EVT_BASE + EW'(EW'(idx_q) * EVT_STEP);
    end

    p_req_above_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(valid && (win_lvl > mask)));
    p_ack_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_q) |=> (blk_q && !irq_q));
    p_blk_holds_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q |-> !irq_q);
    p_rte_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rte && !(ack && irq_q)) |=> !blk_q);
    p_evt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && irq_q) |=> $stable(evt_code));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl (top)
// Prioritized maskable interrupt controller: level registers, arbiter,
// mask gate and the shared handler address. Assumes requests are
// synchronous to clk and held until serviced.
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int              N_SRC    = 8,
    parameter int              LVL_W    = 4,
    parameter int              EVT_W    = 12,
    parameter logic [EVT_W-1:0] EVT_BASE = 12'h400,
    parameter logic [EVT_W-1:0] EVT_STEP = 12'h020,
    parameter int              ADDR_W   = 32,
    localparam int             IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [LVL_W-1:0]  cfg_lvl,
    input  logic [LVL_W-1:0]  cpu_mask,
    input  logic              cpu_ack,
    input  logic              cpu_rte,
    input  logic [ADDR_W-1:0] vec_base,
    output logic              cpu_irq,
    output logic              blk,
    output logic [EVT_W-1:0]  evt_code,
    output logic [ADDR_W-1:0] handler_addr
);
    logic [N_SRC*LVL_W-1:0] levels;
    logic                   valid;
    logic [IDX_W-1:0]       win_idx;
    logic [LVL_W-1:0]       win_lvl;

    irqc_level_regs #(.N(N_SRC), .LW(LVL_W), .IW(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .lvl(cfg_lvl), .levels(levels)
    );

    irqc_arbiter #(.N(N_SRC), .LW(LVL_W), .IW(IDX_W)) u_arb (
        .req(irq_src), .levels(levels), .valid(valid),
        .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irqc_gate #(.LW(LVL_W), .IW(IDX_W), .EW(EVT_W),
                .EVT_BASE(EVT_BASE), .EVT_STEP(EVT_STEP)) u_gate (
        .clk(clk), .rst_n(rst_n), .valid(valid), .win_idx(win_idx),
        .win_lvl(win_lvl), .mask(cpu_mask), .ack(cpu_ack), .rte(cpu_rte),
        .irq_q(cpu_irq), .blk_q(blk), .evt_code(evt_code)
    );

    // Shared handler entry point (R10).
    assign handler_addr = vec_base + ADDR_W'(HANDLER_OFS);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_src = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [3:0]  cfg_lvl = '0;
    logic [3:0]  cpu_mask = '0;
    logic        cpu_ack = 1'b0;
    logic        cpu_rte = 1'b0;
    logic [31:0] vec_base = '0;
    logic        cpu_irq, blk;
    logic [11:0] evt_code;
    logic [31:0] handler_addr;

    int errors = 0;
    int checks = 0;
    int lv [8];

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .cpu_mask(cpu_mask),
        .cpu_ack(cpu_ack), .cpu_rte(cpu_rte), .vec_base(vec_base),
        .cpu_irq(cpu_irq), .blk(blk), .evt_code(evt_code),
        .handler_addr(handler_addr)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lvl_of(input int set, input int i);
        if (set == 0) return 5;
        if (set == 1) return (i * 7 + 2) % 16;
        return i / 2 + 6;
    endfunction

    function automatic logic [11:0] code_of(input int i);
        return 12'h400 + 12'(i * 32);
    endfunction

    task automatic set_lvl(input int i, input int l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_lvl = 4'(l);
        @(negedge clk);
        cfg_we = 1'b0;
        lv[i] = l;
    endtask

    task automatic load_set(input int set);
        for (int i = 0; i < 8; i++) set_lvl(i, lvl_of(set, i));
    endtask

    task automatic run_pattern(input int p, input int m);
        int  w, wl, nmatch;
        bit  v, exp;
        logic [11:0] saved;
        v = 0; w = 0; wl = 0; nmatch = 0;
        for (int i = 0; i < 8; i++)
            if (p[i] && (!v || lv[i] > wl)) begin v = 1; w = i; wl = lv[i]; end
        for (int i = 0; i < 8; i++)
            if (p[i] && lv[i] == wl) nmatch++;
        exp = v && (wl > m);
        @(negedge clk);
        irq_src = 8'(p); cpu_mask = 4'(m);
        @(negedge clk);
        chk(cpu_irq == exp, "R4", 32'(cpu_irq), 32'(exp));
        if (exp) begin
            cpu_ack = 1'b1;
            @(negedge clk);
            cpu_ack = 1'b0;
            chk(evt_code == code_of(w), (nmatch > 1) ? "R3" : "R2", 32'(evt_code), 32'(code_of(w)));
            chk(blk && !cpu_irq, "R6", {30'd0, blk, cpu_irq}, 32'd2);
            irq_src = 8'hFF; cpu_mask = 4'd0;
            @(negedge clk);
            chk(!cpu_irq, "R7", 32'(cpu_irq), 32'd0);
            irq_src = 8'(p); cpu_mask = 4'(m); cpu_rte = 1'b1;
            @(negedge clk);
            cpu_rte = 1'b0;
            chk(!blk && cpu_irq, "R8", {30'd0, blk, cpu_irq}, 32'd1);
        end else if (p % 16 == 0) begin
            saved = evt_code;
            cpu_ack = 1'b1;
            @(negedge clk);
            cpu_ack = 1'b0;
            chk(evt_code == saved && !blk, "R9", {19'd0, blk, evt_code}, {20'd0, saved});
        end
    endtask

    task automatic ack_once();
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
    endtask

    task automatic rte_once();
        @(negedge clk); cpu_rte = 1'b1;
        @(negedge clk); cpu_rte = 1'b0;
    endtask

    initial begin
        #1_900_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) lv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_irq && !blk && evt_code == 0, "R1", {19'd0, blk, evt_code}, 32'd0);
        irq_src = 8'hFF; cpu_mask = 4'd0;
        @(negedge clk); @(negedge clk);
        chk(!cpu_irq, "R1", 32'(cpu_irq), 32'd0);

        // R10: handler address, including wrap-around
        vec_base = 32'h8000_0000; #1;
        chk(handler_addr == 32'h8000_0600, "R10", handler_addr, 32'h8000_0600);
        vec_base = 32'hFFFF_FC00; #1;
        chk(handler_addr == 32'h0000_0200, "R10", handler_addr, 32'h0000_0200);

        // R5: registered request, one-edge latency
        load_set(1);
        @(negedge clk); irq_src = '0; cpu_mask = 4'd0;
        @(negedge clk); irq_src = 8'h10; #1;
        chk(!cpu_irq, "R5", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        chk(cpu_irq, "R5", 32'(cpu_irq), 32'd1);

        // R11: loser stays pending (src4 lvl14 beats src1 lvl9)
        irq_src = 8'h12;
        ack_once();
        chk(evt_code == code_of(4), "R11", 32'(evt_code), 32'(code_of(4)));
        irq_src = 8'h02;
        rte_once();
        chk(cpu_irq, "R11", 32'(cpu_irq), 32'd1);
        ack_once();
        chk(evt_code == code_of(1), "R11", 32'(evt_code), 32'(code_of(1)));
        irq_src = '0;
        rte_once();

        // R12: level rewrite changes the winner (src0 lvl2 -> 15 vs src4 lvl14)
        irq_src = 8'h11;
        set_lvl(0, 15);
        @(negedge clk);
        ack_once();
        chk(evt_code == code_of(0), "R12", 32'(evt_code), 32'(code_of(0)));
        irq_src = '0;
        rte_once();

        // Sweeps: every pattern x every mask, three level layouts
        for (int s = 0; s < 3; s++) begin
            load_set(s);
            for (int m = 0; m < 16; m++)
                for (int p = 0; p < 256; p++)
                    run_pattern(p, m);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule